// File: doc/BRIEF.md
# Asymmetric Three-Slot Decode Steering

This block sits between an instruction aligner and three decode slots. Each cycle it looks at the first three instructions of the queue. Their lengths are already known, and each one comes with a valid bit and the number of uops it needs. The block then decides which instructions the slots decode in this cycle. The head slot is the wide one and can emit up to `BIG_MAX` uops. Every other slot is a narrow one that emits at most a single uop. An instruction needing more uops than the head slot can produce is handed to a microcode sequencer, and only the head slot can do that.

Steering follows program order. A narrow slot holding an instruction that needs more than one uop emits nothing. That slot, and every slot after it, leaves its instruction in the queue, so the blocked instruction reaches the head slot in the next cycle. The aligner shifts out exactly as many instructions as the block reports consumed. The block stalls completely in two cases: while the downstream buffer is not ready, and while the microcode sequencer is running. The steering is combinational over the queue head and one state bit that records whether the sequencer is busy.

Top module: `decode_steer`

## Requirements
- R1: After reset the sequencer is not busy. With no valid input, nothing is consumed and no uops are emitted.
- R2: A valid head instruction needing 1 to `BIG_MAX` (default 4) uops is issued on the wide slot when the stall conditions are clear. `big_uops` equals its count and the instruction is counted as consumed.
- R3: The instruction in lane k (k ≥ 1) is issued when all of the following hold: it needs exactly 1 uop, it is valid, and lane k-1 was issued. Issue sets `lite_vld[k]`. Lane k's count is taken from bits `in_uops[k*CNT_W +: CNT_W]`.
- R4: A narrow lane whose instruction needs more than one uop emits nothing and is not consumed. It therefore comes to the head position in the next cycle.
- R5: Order is kept: once a lane is not issued, no later lane issues in that cycle, even a lane whose instruction needs a single uop.
- R6: An invalid entry ends the group. No lane at or after it issues.
- R7: If the head instruction needs more than `BIG_MAX` uops, all of the following happen in that cycle: `seq_start` pulses, `seq_uops` carries the count, exactly one instruction is consumed, and no slot emits uops. A count of 0 is not a legal input.
- R8: `seq_busy` rises the cycle after `seq_start`. While it is high, nothing is consumed, no uops are emitted and `seq_start` stays low.
- R9: `seq_busy` falls the cycle after `seq_done` is seen while busy. Normal steering resumes in that same cycle.
- R10: While `ds_ready` is low, nothing is consumed, no uops are emitted and no sequence is started.
- R11: A 4/1/1 group consumes three instructions and emits 6 uops in one cycle.
- R12: `take_cnt` equals the number of lanes issued or handed to the sequencer. Over a stream, every instruction is consumed exactly once, and the total of emitted plus sequenced uops equals the sum of the input counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ds_ready | input | 1 | Downstream buffer can accept uops |
| in_vld | input | NSLOT | Valid bit per queue-head lane |
| in_uops | input | NSLOT*CNT_W | Uop count per lane, lane k at bits k*CNT_W |
| take_cnt | output | $clog2(NSLOT+1) | Instructions consumed this cycle |
| big_uops | output | $clog2(BIG_MAX+1) | Uops emitted by the wide slot |
| lite_vld | output | NSLOT-1 (bits NSLOT-1:1) | One-uop valid per narrow slot |
| seq_start | output | 1 | Hand head instruction to microcode sequencer |
| seq_uops | output | CNT_W | Uop count passed with the start |
| seq_busy | output | 1 | Sequencer running; slots held idle |
| seq_done | input | 1 | Sequencer finished its sequence |

## Verification
The steering results `take_cnt`, `big_uops`, `lite_vld`, `seq_start` and `seq_uops` are combinational, so they are due in the same cycle as the inputs. The bench drives each input set just after a falling edge and samples 1 ns later, well before the next rising edge. `seq_busy` is the one registered result. It is due one rising edge after `seq_start` or `seq_done`, so the bench checks it in the next driven cycle. In the randomized stream, the bench advances its own queue pointer and busy model on each rising edge. It then compares every cycle against a sequential reference built from the requirements.

// File: rtl/decode_steer_pkg.sv
package decode_steer_pkg;

   typedef enum logic {
      SQ_IDLE = 1'b0,
      SQ_RUN  = 1'b1
   } seq_state_t;

   function automatic int unsigned width_for(input int unsigned maxval);
      return (maxval < 2) ? 1 : $clog2(maxval + 1);
   endfunction

endpackage

// File: rtl/decode_steer_head.sv
module decode_steer_head #(
   parameter int unsigned CNT_W   = 5,
   parameter int unsigned BIG_MAX = 4,
   parameter int unsigned BIG_W   = 3
) (
   input  logic             en,
   input  logic             vld,
   input  logic [CNT_W-1:0] uops,
   output logic             go,
   output logic             start,
   output logic [BIG_W-1:0] big
);
   logic fits;

   always_comb begin
      fits  = (uops <= CNT_W'(BIG_MAX));
      go    = en & vld & fits;
      start = en & vld & ~fits;
      big   = go ? BIG_W'(uops) : '0;
   end

endmodule

// File: rtl/decode_steer_lane.sv
module decode_steer_lane #(
   parameter int unsigned CNT_W = 5
) (
   input  logic             prev_go,
   input  logic             vld,
   input  logic [CNT_W-1:0] uops,
   output logic             go
);
   always_comb begin
      go = prev_go & vld & (uops == CNT_W'(1));
   end

endmodule

// File: rtl/decode_steer_seq.sv
module decode_steer_seq
   import decode_steer_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic done,
   output logic busy
);
   seq_state_t state_q, state_d;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         SQ_IDLE: if (start) state_d = SQ_RUN;
         SQ_RUN:  if (done)  state_d = SQ_IDLE;
         default: state_d = SQ_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= SQ_IDLE;
      else        state_q <= state_d;
   end

   assign busy = (state_q == SQ_RUN);

endmodule

// File: rtl/decode_steer.sv
module decode_steer
   import decode_steer_pkg::*;
#(
   parameter int unsigned NSLOT   = 3,
   parameter int unsigned CNT_W   = 5,
   parameter int unsigned BIG_MAX = 4
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          ds_ready,
   input  logic [NSLOT-1:0]              in_vld,
   input  logic [NSLOT*CNT_W-1:0]        in_uops,
   output logic [$clog2(NSLOT+1)-1:0]    take_cnt,
   output logic [$clog2(BIG_MAX+1)-1:0]  big_uops,
   output logic [NSLOT-1:1]              lite_vld,
   output logic                          seq_start,
   output logic [CNT_W-1:0]              seq_uops,
   output logic                          seq_busy,
   input  logic                          seq_done
);
   localparam int unsigned TAKE_W = $clog2(NSLOT + 1);
   localparam int unsigned BIG_W  = $clog2(BIG_MAX + 1);

   generate
      if (NSLOT < 2) begin : g_bad_slots
         $error("decode_steer: NSLOT must be at least 2");
      end
      if (BIG_MAX < 2 || BIG_MAX >= (1 << CNT_W) - 1) begin : g_bad_big
         $error("decode_steer: BIG_MAX must be >= 2 and below the count range");
      end
   endgenerate

   logic             en;
   logic [NSLOT-1:0] chain;
   logic             head_start;
   logic [BIG_W-1:0] head_big;

   assign en = ds_ready & ~seq_busy;

   decode_steer_head #(
      .CNT_W   (CNT_W),
      .BIG_MAX (BIG_MAX),
      .BIG_W   (BIG_W)
   ) u_head (
      .en    (en),
      .vld   (in_vld[0]),
      .uops  (in_uops[0 +: CNT_W]),
      .go    (chain[0]),
      .start (head_start),
      .big   (head_big)
   );

   genvar k;
   generate
      for (k = 1; k < NSLOT; k++) begin : g_lane
         decode_steer_lane #(
            .CNT_W (CNT_W)
         ) u_lane (
            .prev_go (chain[k-1]),
            .vld     (in_vld[k]),
            .uops    (in_uops[k*CNT_W +: CNT_W]),
            .go      (chain[k])
         );
         assign lite_vld[k] = chain[k];
      end
   endgenerate

   always_comb begin
      take_cnt = TAKE_W'(head_start);
      for (int i = 0; i < NSLOT; i++) begin
         take_cnt = take_cnt + TAKE_W'(chain[i]);
      end
   end

   assign big_uops  = head_big;
   assign seq_start = head_start;
   assign seq_uops  = head_start ? in_uops[0 +: CNT_W] : '0;

   decode_steer_seq u_seq (
      .clk   (clk),
      .rst_n (rst_n),
      .start (head_start),
      .done  (seq_done),
      .busy  (seq_busy)
   );

endmodule

// File: rtl/decode_steer_chk.sv
module decode_steer_chk #(
   parameter int unsigned NSLOT   = 3,
   parameter int unsigned CNT_W   = 5,
   parameter int unsigned BIG_MAX = 4
) (
   input logic                          clk,
   input logic                          rst_n,
   input logic                          ds_ready,
   input logic [$clog2(NSLOT+1)-1:0]    take_cnt,
   input logic [$clog2(BIG_MAX+1)-1:0]  big_uops,
   input logic [NSLOT-1:1]              lite_vld,
   input logic                          seq_start,
   input logic [CNT_W-1:0]              seq_uops,
   input logic                          seq_busy,
   input logic                          seq_done
);
   AST_BIG_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      big_uops <= ($clog2(BIG_MAX+1))'(BIG_MAX)); // R2

   AST_START_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
      seq_start |-> (take_cnt == 1 && big_uops == 0 && lite_vld == '0
                     && seq_uops > CNT_W'(BIG_MAX))); // R7

   AST_START_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      seq_start |=> seq_busy); // R8

   AST_BUSY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      seq_busy |-> (take_cnt == 0 && big_uops == 0 && lite_vld == '0 && !seq_start)); // R8

   AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (seq_busy && seq_done) |=> !seq_busy); // R9

   AST_STALL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !ds_ready |-> (take_cnt == 0 && big_uops == 0 && lite_vld == '0 && !seq_start)); // R10

   genvar k;
   generate
      for (k = 2; k < NSLOT; k++) begin : g_order
         AST_LANE_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
            lite_vld[k] |-> lite_vld[k-1]); // R5
      end
   endgenerate

   AST_LITE_NEEDS_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
      (lite_vld != '0) |-> (big_uops != 0)); // R3

endmodule

bind decode_steer decode_steer_chk #(
   .NSLOT   (NSLOT),
   .CNT_W   (CNT_W),
   .BIG_MAX (BIG_MAX)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .ds_ready  (ds_ready),
   .take_cnt  (take_cnt),
   .big_uops  (big_uops),
   .lite_vld  (lite_vld),
   .seq_start (seq_start),
   .seq_uops  (seq_uops),
   .seq_busy  (seq_busy),
   .seq_done  (seq_done)
);

// File: tb/decode_steer_bench.sv
`timescale 1ns/100ps
module decode_steer_bench;
   localparam int NI = 40;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ds_ready = 1'b0;
   logic [2:0] in_vld = '0;
   logic [14:0] in_uops = '0;
   logic [1:0] take_cnt;
   logic [2:0] big_uops;
   logic [2:1] lite_vld;
   logic       seq_start;
   logic [4:0] seq_uops;
   logic       seq_busy;
   logic       seq_done = 1'b0;

   int checks = 0;
   int errors = 0;
   int cycles = 0;

   always #2.5 clk = ~clk;

   decode_steer u_decode_steer (
      .clk(clk), .rst_n(rst_n), .ds_ready(ds_ready), .in_vld(in_vld),
      .in_uops(in_uops), .take_cnt(take_cnt), .big_uops(big_uops),
      .lite_vld(lite_vld), .seq_start(seq_start), .seq_uops(seq_uops),
      .seq_busy(seq_busy), .seq_done(seq_done)
   );

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic apply(input logic [2:0] v, input int u0, input int u1, input int u2,
                        input logic rdy, input logic done);
      @(negedge clk);
      in_vld   = v;
      in_uops  = {5'(u2), 5'(u1), 5'(u0)};
      ds_ready = rdy;
      seq_done = done;
      #1;
   endtask

   task automatic expect_out(input string tag, input int t, input int b, input int l,
                             input int s);
      chk({tag, " take"}, int'(take_cnt), t);
      chk({tag, " big"}, int'(big_uops), b);
      chk({tag, " lite"}, int'(lite_vld), l);
      chk({tag, " start"}, int'(seq_start), s);
   endtask

   task automatic t_reset();
      apply(3'b000, 0, 0, 0, 1'b1, 1'b0);
      chk("R1 busy", int'(seq_busy), 0);
      expect_out("R1", 0, 0, 0, 0);
   endtask

   task automatic t_head();
      apply(3'b001, 3, 0, 0, 1'b1, 1'b0);
      expect_out("R2 three", 1, 3, 0, 0);
      apply(3'b001, 4, 0, 0, 1'b1, 1'b0);
      expect_out("R2 four", 1, 4, 0, 0);
      apply(3'b011, 1, 1, 0, 1'b1, 1'b0);
      expect_out("R3 pair", 2, 1, 2'b01, 0);
   endtask

   task automatic t_peak();
      apply(3'b111, 4, 1, 1, 1'b1, 1'b0);
      expect_out("R11 411", 3, 4, 2'b11, 0);
      chk("R11 total", int'(big_uops) + int'(lite_vld[1]) + int'(lite_vld[2]), 6);
   endtask

   task automatic t_block();
      apply(3'b111, 1, 2, 1, 1'b1, 1'b0);
      expect_out("R4 R5 blocked lane", 1, 1, 2'b00, 0);
      apply(3'b011, 2, 1, 0, 1'b1, 1'b0);
      expect_out("R4 shifted to head", 2, 2, 2'b01, 0);
      apply(3'b111, 2, 1, 3, 1'b1, 1'b0);
      expect_out("R5 lane2 multi", 2, 2, 2'b01, 0);
   endtask

   task automatic t_invalid();
      apply(3'b101, 2, 1, 1, 1'b1, 1'b0);
      expect_out("R6 gap", 1, 2, 2'b00, 0);
      apply(3'b110, 1, 1, 1, 1'b1, 1'b0);
      expect_out("R6 head invalid", 0, 0, 2'b00, 0);
   endtask

   task automatic t_stall();
      apply(3'b111, 4, 1, 1, 1'b0, 1'b0);
      expect_out("R10 stall", 0, 0, 0, 0);
      apply(3'b001, 9, 0, 0, 1'b0, 1'b0);
      expect_out("R10 stall seq", 0, 0, 0, 0);
      apply(3'b001, 9, 0, 0, 1'b0, 1'b0);
      chk("R10 no busy", int'(seq_busy), 0);
   endtask

   task automatic t_micro();
      apply(3'b111, 1, 9, 1, 1'b1, 1'b0);
      expect_out("R4 long in lane", 1, 1, 0, 0);
      apply(3'b011, 9, 1, 0, 1'b1, 1'b0);
      expect_out("R7 start", 1, 0, 0, 1);
      chk("R7 seq_uops", int'(seq_uops), 9);
      chk("R8 not yet busy", int'(seq_busy), 0);
      apply(3'b001, 1, 0, 0, 1'b1, 1'b0);
      chk("R8 busy", int'(seq_busy), 1);
      expect_out("R8 idle", 0, 0, 0, 0);
      apply(3'b001, 1, 0, 0, 1'b1, 1'b1);
      chk("R8 still busy", int'(seq_busy), 1);
      expect_out("R8 idle done", 0, 0, 0, 0);
      apply(3'b001, 1, 0, 0, 1'b1, 1'b0);
      chk("R9 cleared", int'(seq_busy), 0);
      expect_out("R9 resume", 1, 1, 0, 0);
   endtask

   task automatic t_stream();
      int q[0:NI+2];
      int ptr = 0;
      int mbusy = 0;
      int mcnt = 0;
      int sum_in = 0;
      int sum_out = 0;
      int sum_take = 0;
      int mism = 0;
      for (int i = 0; i < NI + 3; i++) begin
         if (i < NI) begin
            q[i] = ($urandom_range(0, 2) == 0) ? 1 : int'($urandom_range(1, 7));
            sum_in += q[i];
         end else begin
            q[i] = 0;
         end
      end
      for (int cyc = 0; cyc < 800 && ptr < NI; cyc++) begin
         logic [2:0] v;
         logic       rdy;
         logic       dn;
         int e_take;
         int e_big;
         int e_lite;
         int e_start;
         for (int k = 0; k < 3; k++) v[k] = (ptr + k) < NI;
         rdy = ($urandom_range(0, 3) != 0);
         dn  = (mbusy != 0) && (mcnt >= 2);
         apply(v, q[ptr], q[ptr+1], q[ptr+2], rdy, dn);
         e_take = 0; e_big = 0; e_lite = 0; e_start = 0;
         if (mbusy == 0 && rdy && v[0]) begin
            e_take = 1;
            if (q[ptr] > 4) e_start = 1;
            else begin
               e_big = q[ptr];
               for (int k = 1; k < 3; k++) begin
                  if (v[k] && q[ptr+k] == 1 && e_take == k) begin
                     e_lite |= (1 << (k - 1));
                     e_take++;
                  end
               end
            end
         end
         if (int'(take_cnt) != e_take || int'(big_uops) != e_big ||
             int'(lite_vld) != e_lite || int'(seq_start) != e_start) begin
            mism++;
            $display("FAIL R12 stream cycle %0d: actual t%0d b%0d l%0d s%0d expected t%0d b%0d l%0d s%0d",
                     cyc, take_cnt, big_uops, lite_vld, seq_start, e_take, e_big, e_lite, e_start);
         end
         sum_take += int'(take_cnt);
         sum_out  += int'(big_uops) + int'(lite_vld[1]) + int'(lite_vld[2])
                     + (seq_start ? int'(seq_uops) : 0);
         @(posedge clk);
         ptr += e_take;
         if (e_start != 0) begin mbusy = 1; mcnt = 0; end
         else if (mbusy != 0 && dn) mbusy = 0;
         else if (mbusy != 0) mcnt++;
      end
      checks++;
      if (mism != 0) errors++;
      chk("R12 stream drained", ptr, NI);
      chk("R12 consumed once", sum_take, NI);
      chk("R12 uop total", sum_out, sum_in);
      apply(3'b000, 0, 0, 0, 1'b1, mbusy != 0);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      t_reset();
      t_head();
      t_peak();
      t_block();
      t_invalid();
      t_stall();
      t_micro();
      t_stream();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule